// File: doc/BRIEF.md
# Block-write configuration register slave on a two-wire serial bus

This block is a two-wire serial bus target (SCL/SDA, standard-mode 100 kbit/s) that owns six 8-bit configuration registers of a clock-generation chip. The bus lines are brought into the system clock domain through a two-flop synchronizer, and all protocol work happens on the system clock. START and STOP are recognised as SDA edges while SCL is high. The block drives SDA only by pulling it low, through an open-drain output enable. It never stretches the clock.

A write is framed as the write address (byte 0xD2), then a command byte, then a count byte, then data. The command and count bytes are acknowledged, and their values are thrown away. Data bytes always land in register 0 first and go on upward, one register per byte, until STOP. Bytes that go past the last register are acknowledged and dropped. A read uses the read address (byte 0xD3). The block then sends the constant count 6, followed by register 0, 1, 2 and onward, each byte MSB first. Past the last register it sends 0xFF. The read ends when the master answers a byte with NACK. The rest of the chip sees the registers as a flat, always-valid parallel bus. This bus is a plain level output with no handshake, so back-pressure never arises: a register takes a new value in the cycle after its byte is accepted, and consumers read it whenever they need it.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The address byte 0xD2 (7-bit address 0x69, R/W=0) and the address byte 0xD3 (R/W=1) are both acknowledged: the block pulls SDA low during the ninth SCL pulse.
- R2: In a write, the two bytes that follow the address (command, then count) are acknowledged, and neither byte changes any register.
- R3: In a write, the third and later bytes load register 0, 1, 2 and onward in ascending order. On `cfg_q`, register k sits at bits [8k+7:8k].
- R4: A STOP after any complete byte leaves the registers already written with their new values and every other register unchanged. A byte cut short by STOP writes nothing. Registers change only as the result of an accepted data byte.
- R5: After the read address, the block sends the count byte 6, then register 0, 1, 2 and onward, MSB first. No register is written during a read.
- R6: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF.
- R7: In a write, data bytes beyond register 5 are acknowledged and change nothing.
- R8: An address byte other than 0xD2 or 0xD3 gets no acknowledge. The block then acknowledges nothing and writes nothing until the next START, even if a later byte matches the address.
- R9: In a read, bytes beyond register 5 return 0xFF. After the master's NACK, the block releases SDA.
- R10: A repeated START in the middle of a transfer restarts address reception, and the new transfer behaves as a fresh write or read.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| cfg_q | output | 48 | Register contents, register k at bits [8k+7:8k] |

## Verification
Two situations are the hardest to reach from the pins: a register write that falls past the last register, and a transfer cut short in the middle of a byte. The stimulus reaches the first with an eight-byte data burst after the command and count bytes. It reaches the second with a master task that sends only four bits of a byte before issuing STOP. Ignore mode gets a byte that matches the address right after a mismatched address, to show that only START can bring the block back. A repeated START follows a write with a read-back, so the same stimulus also checks the framing reset and the register contents.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXBITS,
    ST_ACK,
    ST_TXBITS,
    ST_MACK,
    ST_IGNORE
  } st_t;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_CNT,
    PH_DATA
  } wph_t;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cfgi2c_regfile.sv
module cfgi2c_regfile #(
  parameter int         NREG      = 6,
  parameter logic [7:0] RST_FIRST = 8'h00,
  parameter logic [7:0] RST_REST  = 8'hFF,
  parameter logic [7:0] FILL      = 8'hFF,
  parameter int         IW        = 3,
  parameter int         PW        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [7:0]      wdata,
  input  logic [PW-1:0]   ridx,
  output logic [7:0]      rdata,
  output logic [NREG*8-1:0] q
);
  logic [7:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [7:0] RV = (k == 0) ? RST_FIRST : RST_REST;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[k] <= RV;
      else if (we && widx == IW'(k))       regs[k] <= wdata;
    end
    assign q[8*k +: 8] = regs[k];
  end

  always_comb begin
    rdata = FILL;
    for (int k = 0; k < NREG; k++)
      if (ridx == PW'(k)) rdata = regs[k];
  end
endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
  import cfgi2c_pkg::*;
#(
  parameter int         NREG       = 6,
  parameter logic [6:0] ADDR7      = 7'h69,
  parameter logic [7:0] BYTE_COUNT = 8'd6,
  parameter int         IW         = 3,
  parameter int         PW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] rd_idx,
  output logic          rd_active
);
  localparam logic [PW-1:0] NPTR = PW'(NREG);

  st_t           st;
  wph_t          wph;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx_sh;
  logic          rw, in_addr, nack;
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; wph <= PH_CMD; cnt <= '0; sh <= '0; tx_sh <= '0;
      rw <= 1'b0; in_addr <= 1'b0; nack <= 1'b0; ptr <= '0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_RXBITS; cnt <= '0; in_addr <= 1'b1;
        sda_oe <= 1'b0; ptr <= '0; wph <= PH_CMD;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RXBITS: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              in_addr <= 1'b0;
              if (in_addr) begin
                if (sh[7:1] == ADDR7) begin
                  rw <= sh[0]; sda_oe <= 1'b1; st <= ST_ACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end else begin
                sda_oe <= 1'b1; st <= ST_ACK;
                unique case (wph)
                  PH_CMD:  wph <= PH_CNT;
                  PH_CNT:  wph <= PH_DATA;
                  default: if (ptr < NPTR) begin
                    wr_en <= 1'b1; wr_idx <= IW'(ptr); wr_data <= sh;
                    ptr <= ptr + 1'b1;
                  end
                endcase
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx_sh <= BYTE_COUNT; sda_oe <= ~BYTE_COUNT[7]; st <= ST_TXBITS;
            end else begin
              sda_oe <= 1'b0; st <= ST_RXBITS;
            end
          end
          ST_TXBITS: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= ST_MACK;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0}; sda_oe <= ~tx_sh[6];
              cnt <= cnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= ST_IGNORE;
              else begin
                tx_sh <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0;
                st <= ST_TXBITS;
                if (ptr < NPTR) ptr <= ptr + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx    = ptr;
  assign rd_active = (st == ST_TXBITS) || (st == ST_MACK);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NREG        = 6,
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter logic [7:0] RST_FIRST   = 8'h00,
  parameter logic [7:0] RST_REST    = 8'hFF,
  parameter logic [7:0] FILL        = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);
  localparam int         IW         = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int         PW         = $clog2(NREG + 1);
  localparam logic [7:0] BYTE_COUNT = 8'(NREG);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, rd_active;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data, rd_data;
  logic [PW-1:0] rd_idx;

  cfgi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgi2c_proto #(
    .NREG(NREG), .ADDR7(ADDR7), .BYTE_COUNT(BYTE_COUNT), .IW(IW), .PW(PW)
  ) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_active(rd_active)
  );

  cfgi2c_regfile #(
    .NREG(NREG), .RST_FIRST(RST_FIRST), .RST_REST(RST_REST), .FILL(FILL),
    .IW(IW), .PW(PW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(rd_data), .q(cfg_q)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int         NREG      = 6,
  parameter logic [7:0] RST_FIRST = 8'h00,
  parameter logic [7:0] RST_REST  = 8'hFF,
  parameter int         IW        = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_q,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx,
  input logic              rd_active
);
  localparam logic [NREG*8-1:0] RST_VEC =
    {{(NREG-1){RST_REST}}, RST_FIRST};

  // R6: register values right after reset release
  a_r6_reset_defaults: assert property (@(posedge clk)
    $rose(rst_n) |-> cfg_q == RST_VEC);

  // R4: registers move only after an accepted data byte
  a_r4_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(wr_en));

  // R7: no write strobe ever targets a missing register
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < NREG));

  // R5: reading never writes
  a_r5_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !wr_en);

  // R11: SDA drive changes only while SCL is low
  a_r11_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(
  .NREG(NREG), .RST_FIRST(RST_FIRST), .RST_REST(RST_REST), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_q(cfg_q),
  .wr_en(wr_en), .wr_idx(wr_idx), .rd_active(rd_active)
);

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;
  localparam int Q = 10;
  localparam int NREG = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_lo = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_q;
  wire  sda_bus = !(m_sda_lo || sda_oe);

  int total = 0, bad = 0, cyc = 0, last_chg = 0;
  int exp_reg[NREG];
  bit pend_on = 0;
  int pend_idx = 0;
  logic [7:0] pend_val = '0;
  string cur_req = "R6";
  bit done = 0;

  always #10 clk = ~clk;

  cfg_i2c_slave u_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  function automatic logic [NREG*8-1:0] exp_vec();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[8*k +: 8] = exp_reg[k][7:0];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // cycle-by-cycle comparison of the register bus against the model
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && (cyc - last_chg > 8))
      check(cfg_q == exp_vec(), cur_req, cfg_q, exp_vec());
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask
  task automatic set_scl(input logic v); m_scl = v; last_chg = cyc; endtask

  task automatic bit_out(input logic b);
    m_sda_lo = !b; wq(Q);
    set_scl(1); wq(2*Q);
    set_scl(0);
    if (pend_on) begin exp_reg[pend_idx] = pend_val; pend_on = 0; end
    wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit exp_ack, input int commit, input string req);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && commit >= 0) begin pend_on = 1; pend_idx = commit; pend_val = b; end
      bit_out(b[i]);
    end
    m_sda_lo = 0; wq(Q);
    set_scl(1); wq(Q);
    got = !sda_bus;
    check(got == exp_ack, req, got, exp_ack);
    wq(Q); set_scl(0); wq(Q);
  endtask

  task automatic rbyte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] v = '0;
    logic mid;
    for (int i = 0; i < 8; i++) begin
      m_sda_lo = 0; wq(Q);
      set_scl(1); wq(Q);
      v = {v[6:0], sda_bus}; mid = sda_oe;
      wq(Q - 1);
      check(sda_oe == mid, "R11", sda_oe, mid);
      wq(1); set_scl(0); wq(Q);
    end
    check(v == exp, req, v, exp);
    m_sda_lo = mack; wq(Q);
    set_scl(1); wq(2*Q);
    set_scl(0); wq(Q);
    m_sda_lo = 0;
  endtask

  task automatic do_start();
    m_sda_lo = 0; wq(Q);
    set_scl(1); wq(Q);
    m_sda_lo = 1; wq(Q);
    set_scl(0); wq(Q);
  endtask

  task automatic do_stop();
    m_sda_lo = 1; wq(Q);
    set_scl(1); wq(Q);
    m_sda_lo = 0; wq(2*Q);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) exp_reg[k] = (k == 0) ? 8'h00 : 8'hFF;
    wq(5); rst_n = 1; wq(3);
    check(cfg_q == 48'hFFFF_FFFF_FF00, "R6", cfg_q, 48'hFFFF_FFFF_FF00);

    // R1 R2 R3: short write, command and count ignored
    cur_req = "R3";
    do_start();
    wbyte(8'hD2, 1, -1, "R1");
    wbyte(8'hA5, 1, -1, "R2");
    wbyte(8'h03, 1, -1, "R2");
    wbyte(8'h11, 1, 0, "R3");
    wbyte(8'h22, 1, 1, "R3");
    wbyte(8'h33, 1, 2, "R3");
    do_stop(); wq(4);
    check(cfg_q == 48'hFFFF_FF33_2211, "R4", cfg_q, 48'hFFFF_FF33_2211);

    // R7: overrun past the last register
    cur_req = "R7";
    do_start();
    wbyte(8'hD2, 1, -1, "R1");
    wbyte(8'h00, 1, -1, "R2");
    wbyte(8'hFF, 1, -1, "R2");
    for (int k = 0; k < 8; k++)
      wbyte(8'h40 + 8'(k), 1, (k < NREG) ? k : -1, "R7");
    do_stop(); wq(4);
    check(cfg_q == 48'h4544_4342_4140, "R7", cfg_q, 48'h4544_4342_4140);

    // R8: wrong address, then a byte that matches the address
    cur_req = "R8";
    do_start();
    wbyte(8'hA4, 0, -1, "R8");
    wbyte(8'hD2, 0, -1, "R8");
    wbyte(8'h00, 0, -1, "R8");
    wbyte(8'h00, 0, -1, "R8");
    wbyte(8'h5A, 0, -1, "R8");
    do_stop(); wq(4);
    check(cfg_q == 48'h4544_4342_4140, "R8", cfg_q, 48'h4544_4342_4140);

    // R5 R9: read count, registers, then fill bytes
    cur_req = "R5";
    do_start();
    wbyte(8'hD3, 1, -1, "R1");
    rbyte(8'd6, 1, "R5");
    for (int k = 0; k < NREG; k++) rbyte(8'h40 + 8'(k), 1, "R5");
    rbyte(8'hFF, 1, "R9");
    rbyte(8'hFF, 0, "R9");
    wq(Q);
    check(sda_oe == 0, "R9", sda_oe, 0);
    do_stop();

    // R4: STOP in the middle of a byte
    cur_req = "R4";
    do_start();
    wbyte(8'hD2, 1, -1, "R1");
    wbyte(8'h01, 1, -1, "R2");
    wbyte(8'h02, 1, -1, "R2");
    wbyte(8'h77, 1, 0, "R4");
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop(); wq(4);
    check(cfg_q == 48'h4544_4342_4177, "R4", cfg_q, 48'h4544_4342_4177);

    // R10: write, repeated START, read back
    cur_req = "R10";
    do_start();
    wbyte(8'hD2, 1, -1, "R1");
    wbyte(8'h9C, 1, -1, "R2");
    wbyte(8'h01, 1, -1, "R2");
    wbyte(8'h99, 1, 0, "R10");
    do_start();
    wbyte(8'hD3, 1, -1, "R10");
    rbyte(8'd6, 1, "R10");
    rbyte(8'h99, 1, "R10");
    rbyte(8'h41, 0, "R10");
    do_stop(); wq(20);

    finish_run();
  end
endmodule